// File: doc/BRIEF.md
# External Asynchronous Memory Bus Controller

This block turns single requests from an on-chip port into cycles on an external asynchronous memory bus. A request carries a 20-bit byte address, a direction, a size (byte or 16-bit word) and write data. It is taken with a valid/ready handshake, and it is answered by a one-clock response pulse that carries the read data. On the pin side the controller drives an address bus, a data bus of 8 or 16 bits, four active-low chip selects, a read strobe, two write-strobe pins and an address latch enable. The chip selects come from a fixed map on the top address bits.

Three static configuration inputs shape the cycle. The first picks the data bus width. The second picks between separate and multiplexed address/data lines. The third picks between two write-strobe schemes. In the split scheme each byte lane has its own write strobe. In the combined scheme there is one write strobe plus a byte-high-enable. An external ready input stretches the strobe phase. An external hold request makes the controller float the bus between cycles and acknowledge the hold.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, all strobes and chip selects are high, `ext_ale` is 0, `ext_hlda_n` is 1 and `req_ready` is 1.
- R2: Every bus cycle opens with exactly one clock of `ext_ale` high, carrying the address and the chip select. The strobe phase follows. ALE never overlaps an active strobe.
- R3: The strobe stays low for at least one clock. Each clock at whose closing edge `ext_rdy_n` is low adds one more clock. Read data is taken at the last strobe edge and appears on `rsp_rdata`, with `rsp_valid` high, in the next clock.
- R4: Chip select `ext_cs_n[i]` is low during the address and strobe phases when address bits [19:18] equal i. At most one chip select is low.
- R5: Split scheme (`cfg_split`=1, 16-bit bus): an even byte write pulls `ext_wstb_lo_n` low, an odd byte write pulls `ext_wstb_hi_n` low, and a word write pulls both low.
- R6: Combined scheme: `ext_wstb_lo_n` is the single write strobe for any write. `ext_wstb_hi_n` is a byte-high-enable, low through the address and strobe phases of an odd-address access or of a word access on the 16-bit bus. With `cfg_bus8`=1 the combined scheme applies whatever `cfg_split` says.
- R7: On the 16-bit bus (`cfg_bus8`=0), an even byte uses D[7:0] and an odd byte uses D[15:8]. A word uses all 16 lines at the address with bit 0 cleared. A byte read returns its byte on `rsp_rdata[7:0]` with the upper byte zero.
- R8: On the 8-bit bus (`cfg_bus8`=1), a word becomes two byte cycles on D[7:0]. The first is at the even address and carries the low byte. The second is at the odd address and carries the high byte. A single response returns both bytes assembled.
- R9: In multiplexed mode (`cfg_mux`=1), D[7:0] is driven during the ALE clock with address bits [7:0] on the 8-bit bus, or with bits [8:1] on the 16-bit bus. In separate mode the data lines are not driven during a read.
- R10: When `ext_hold_n` is low in idle, the controller enters hold from the next clock. In hold `ext_hlda_n` is 0, `ext_ctl_oe` and `ext_data_oe` are 0, and `req_ready` is 0. A pending request waits and starts after `ext_hold_n` returns high.
- R11: A hold request that arrives during a bus cycle is granted only after that cycle ends. `ext_hlda_n` stays high while ALE or a strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bus8 | input | 1 | 1: 8-bit data bus, 0: 16-bit data bus |
| cfg_mux | input | 1 | 1: multiplexed address/data |
| cfg_split | input | 1 | 1: per-lane write strobes (16-bit bus only) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1: write, 0: read |
| req_word | input | 1 | 1: 16-bit access, 0: byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data (byte in [7:0]) |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data |
| ext_addr_o | output | 20 | External address |
| ext_ctl_oe | output | 1 | Enable for address, chip select, strobe and ALE pins |
| ext_data_o | output | 16 | External data out |
| ext_data_oe | output | 1 | Data pin drive enable |
| ext_data_i | input | 16 | External data in |
| ext_cs_n | output | 4 | Active-low chip selects |
| ext_rd_n | output | 1 | Read strobe |
| ext_wstb_lo_n | output | 1 | Low-lane write strobe / single write strobe |
| ext_wstb_hi_n | output | 1 | High-lane write strobe / byte-high-enable |
| ext_ale | output | 1 | Address latch enable |
| ext_rdy_n | input | 1 | Low stretches the strobe |
| ext_hold_n | input | 1 | Low requests the bus |
| ext_hlda_n | output | 1 | Low acknowledges hold |

## Verification
The assertions check on every cycle:
- that ALE and the strobes never overlap, and that each read strobe is preceded by ALE;
- that a strobe stays low while ready is low;
- that at most one chip select is active;
- that read and write strobes are never low together;
- that the pins float with ready low while hold is acknowledged, and that hold is never acknowledged during ALE or a strobe.

Only the directed scenarios can show the values carried on the pins. These are the byte-lane placement, the strobe choice for each scheme, the multiplexed address field, the two-cycle word split on the 8-bit bus and the returned read data. The scenarios also measure the exact strobe length for a given wait count and the order of hold against a pending request.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HOLD,
      ST_ADDR,
      ST_STRB,
      ST_END
   } bus_state_e;
endpackage

// File: rtl/xbus_lane.sv
// Byte-lane steering: which lanes a phase uses, what the data pins carry,
// and which address field is muxed onto D[7:0] during the ALE clock.
module xbus_lane #(
   parameter int AW = 20,
   parameter int DW = 16,
   localparam int BW = DW / 2
) (
   input  logic [AW-1:0] cur_addr,
   input  logic          word,
   input  logic          bus8,
   input  logic          second,
   input  logic [DW-1:0] wdata,
   output logic          lane_lo,
   output logic          lane_hi,
   output logic [DW-1:0] lane_data,
   output logic [BW-1:0] mux_field
);
   logic [BW-1:0] byte_sel;

   always_comb begin
      byte_sel = (bus8 && word && second) ? wdata[DW-1:BW] : wdata[BW-1:0];
      if (bus8) begin
         lane_lo   = 1'b1;
         lane_hi   = 1'b0;
         lane_data = {{BW{1'b0}}, byte_sel};
         mux_field = cur_addr[BW-1:0];
      end else begin
         lane_lo   = word | ~cur_addr[0];
         lane_hi   = word | cur_addr[0];
         mux_field = cur_addr[BW:1];
         if (word)
            lane_data = wdata;
         else if (cur_addr[0])
            lane_data = {byte_sel, {BW{1'b0}}};
         else
            lane_data = {{BW{1'b0}}, byte_sel};
      end
   end
endmodule

// File: rtl/xbus_seq.sv
// Cycle sequencer: idle/hold arbitration, address-strobe-end phases,
// ready stretching, word split on the narrow bus, read capture.
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int AW = 20,
   parameter int DW = 16,
   localparam int BW = DW / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus8,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic          req_word,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          rdy_n,
   input  logic          hold_n,
   input  logic [DW-1:0] data_i,
   output bus_state_e    state,
   output logic [AW-1:0] cur_addr,
   output logic          lat_write,
   output logic          lat_word,
   output logic [DW-1:0] lat_wdata,
   output logic          second,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata
);
   logic [AW-1:0] lat_addr;
   logic          last_phase;

   assign cur_addr   = {lat_addr[AW-1:1], lat_word ? second : lat_addr[0]};
   assign last_phase = !(bus8 && lat_word) || second;
   assign req_ready  = (state == ST_IDLE) && hold_n;
   assign rsp_valid  = (state == ST_END) && last_phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         lat_addr  <= '0;
         lat_write <= 1'b0;
         lat_word  <= 1'b0;
         lat_wdata <= '0;
         second    <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (!hold_n) begin
                  state <= ST_HOLD;
               end else if (req_valid) begin
                  lat_addr  <= req_addr;
                  lat_write <= req_write;
                  lat_word  <= req_word;
                  lat_wdata <= req_wdata;
                  second    <= 1'b0;
                  state     <= ST_ADDR;
               end
            end
            ST_HOLD: if (hold_n) state <= ST_IDLE;
            ST_ADDR: state <= ST_STRB;
            ST_STRB: begin
               if (rdy_n) begin
                  state <= ST_END;
                  if (!lat_write) begin
                     if (bus8) begin
                        if (!lat_word)   rsp_rdata <= {{BW{1'b0}}, data_i[BW-1:0]};
                        else if (second) rsp_rdata[DW-1:BW] <= data_i[BW-1:0];
                        else             rsp_rdata[BW-1:0]  <= data_i[BW-1:0];
                     end else if (lat_word) begin
                        rsp_rdata <= data_i;
                     end else if (cur_addr[0]) begin
                        rsp_rdata <= {{BW{1'b0}}, data_i[DW-1:BW]};
                     end else begin
                        rsp_rdata <= {{BW{1'b0}}, data_i[BW-1:0]};
                     end
                  end
               end
            end
            ST_END: begin
               if (last_phase) begin
                  state <= ST_IDLE;
               end else begin
                  second <= 1'b1;
                  state  <= ST_ADDR;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
   import xbus_pkg::*;
#(
   parameter int AW     = 20,
   parameter int DW     = 16,
   parameter int NUM_CS = 4,
   localparam int BW    = DW / 2,
   localparam int SEL_W = $clog2(NUM_CS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_bus8,
   input  logic              cfg_mux,
   input  logic              cfg_split,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [AW-1:0]     req_addr,
   input  logic [DW-1:0]     req_wdata,
   output logic              rsp_valid,
   output logic [DW-1:0]     rsp_rdata,
   output logic [AW-1:0]     ext_addr_o,
   output logic              ext_ctl_oe,
   output logic [DW-1:0]     ext_data_o,
   output logic              ext_data_oe,
   input  logic [DW-1:0]     ext_data_i,
   output logic [NUM_CS-1:0] ext_cs_n,
   output logic              ext_rd_n,
   output logic              ext_wstb_lo_n,
   output logic              ext_wstb_hi_n,
   output logic              ext_ale,
   input  logic              ext_rdy_n,
   input  logic              ext_hold_n,
   output logic              ext_hlda_n
);
   if (DW != 16) begin : g_bad_dw
      $error("xbus_ctrl: DW must be 16");
   end
   if (AW < BW + 2 || AW < SEL_W + 1) begin : g_bad_aw
      $error("xbus_ctrl: AW too small");
   end
   if (NUM_CS < 2 || (1 << SEL_W) != NUM_CS) begin : g_bad_cs
      $error("xbus_ctrl: NUM_CS must be a power of two >= 2");
   end

   bus_state_e    state;
   logic [AW-1:0] cur_addr;
   logic          lat_write, lat_word, second;
   logic [DW-1:0] lat_wdata, lane_data;
   logic [BW-1:0] mux_field;
   logic          lane_lo, lane_hi;
   logic          in_cycle, strb, split_eff, bhe_need;
   logic [SEL_W-1:0] cs_idx;

   xbus_seq #(.AW(AW), .DW(DW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus8      (cfg_bus8),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_write (req_write),
      .req_word  (req_word),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rdy_n     (ext_rdy_n),
      .hold_n    (ext_hold_n),
      .data_i    (ext_data_i),
      .state     (state),
      .cur_addr  (cur_addr),
      .lat_write (lat_write),
      .lat_word  (lat_word),
      .lat_wdata (lat_wdata),
      .second    (second),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   xbus_lane #(.AW(AW), .DW(DW)) u_lane (
      .cur_addr  (cur_addr),
      .word      (lat_word),
      .bus8      (cfg_bus8),
      .second    (second),
      .wdata     (lat_wdata),
      .lane_lo   (lane_lo),
      .lane_hi   (lane_hi),
      .lane_data (lane_data),
      .mux_field (mux_field)
   );

   assign in_cycle  = (state == ST_ADDR) || (state == ST_STRB);
   assign strb      = (state == ST_STRB);
   assign split_eff = cfg_split && !cfg_bus8;
   assign bhe_need  = cfg_bus8 ? cur_addr[0] : lane_hi;
   assign cs_idx    = cur_addr[AW-1 -: SEL_W];

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign ext_cs_n[i] = !(in_cycle && (cs_idx == SEL_W'(i)));
   end

   assign ext_addr_o  = cur_addr;
   assign ext_ctl_oe  = (state != ST_HOLD);
   assign ext_hlda_n  = (state != ST_HOLD);
   assign ext_ale     = (state == ST_ADDR);
   assign ext_rd_n    = !(strb && !lat_write);

   always_comb begin
      if (split_eff) begin
         ext_wstb_lo_n = !(strb && lat_write && lane_lo);
         ext_wstb_hi_n = !(strb && lat_write && lane_hi);
      end else begin
         ext_wstb_lo_n = !(strb && lat_write);
         ext_wstb_hi_n = !(in_cycle && bhe_need);
      end
      if (state == ST_ADDR && cfg_mux) begin
         ext_data_o  = {{BW{1'b0}}, mux_field};
         ext_data_oe = 1'b1;
      end else begin
         ext_data_o  = lane_data;
         ext_data_oe = lat_write && (strb || state == ST_END);
      end
   end
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
   parameter int NUM_CS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_bus8,
   input logic              cfg_split,
   input logic              req_ready,
   input logic              ext_ctl_oe,
   input logic              ext_data_oe,
   input logic [NUM_CS-1:0] ext_cs_n,
   input logic              ext_rd_n,
   input logic              ext_wstb_lo_n,
   input logic              ext_wstb_hi_n,
   input logic              ext_ale,
   input logic              ext_rdy_n,
   input logic              ext_hlda_n
);
   a_r2_ale_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ext_ale |-> (ext_rd_n && ext_wstb_lo_n && (ext_wstb_hi_n || !(cfg_split && !cfg_bus8))));

   a_r2_read_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ext_rd_n) |-> $past(ext_ale));

   a_r3_stretch: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_rd_n && !ext_rdy_n) |=> !ext_rd_n);

   a_r4_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ext_cs_n));

   a_r6_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ext_rd_n && !ext_wstb_lo_n));

   a_r10_hold_floats: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_hlda_n |-> (!ext_ctl_oe && !ext_data_oe && !req_ready));

   a_r11_no_hold_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_ale || !ext_rd_n || !ext_wstb_lo_n) |-> ext_hlda_n);
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.NUM_CS(NUM_CS)) u_chk (.*);

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_bus8 = 1'b0, cfg_mux = 1'b0, cfg_split = 1'b1;
   logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready, rsp_valid;
   logic [15:0] rsp_rdata;
   logic [19:0] ext_addr_o;
   logic        ext_ctl_oe, ext_data_oe;
   logic [15:0] ext_data_o;
   logic [15:0] ext_data_i = '0;
   logic [3:0]  ext_cs_n;
   logic        ext_rd_n, ext_wstb_lo_n, ext_wstb_hi_n, ext_ale;
   logic        ext_rdy_n = 1'b1, ext_hold_n = 1'b1;
   logic        ext_hlda_n;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   xbus_ctrl u_dut (.*);

   // captured per phase
   logic [19:0] c_addr[2];
   logic [3:0]  c_cs[2];
   logic        c_ale[2], c_ale_doe[2], c_bhe[2], c_wlo[2], c_whi[2], c_rd[2], c_soe[2];
   logic [15:0] c_ale_data[2], c_dout[2];
   int          c_slen[2];
   logic [15:0] c_rdata;
   int          nph;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic strobe_low();
      return !ext_rd_n || !ext_wstb_lo_n ||
             (!ext_wstb_hi_n && !ext_ale && cfg_split && !cfg_bus8);
   endfunction

   task automatic bus_op(input logic wr, input logic wd, input logic [19:0] a,
                         input logic [15:0] wdat, input int waits);
      int ph = 0;
      logic done = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = wdat;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done && ph < 2) begin
         c_addr[ph] = ext_addr_o; c_cs[ph] = ext_cs_n; c_ale[ph] = ext_ale;
         c_ale_doe[ph] = ext_data_oe; c_ale_data[ph] = ext_data_o; c_bhe[ph] = ext_wstb_hi_n;
         c_slen[ph] = 0;
         @(negedge clk);
         c_wlo[ph] = ext_wstb_lo_n; c_whi[ph] = ext_wstb_hi_n; c_rd[ph] = ext_rd_n;
         c_dout[ph] = ext_data_o; c_soe[ph] = ext_data_oe;
         while (strobe_low() && c_slen[ph] < 20) begin
            ext_rdy_n = (c_slen[ph] < waits) ? 1'b0 : 1'b1;
            c_slen[ph]++;
            @(negedge clk);
         end
         ext_rdy_n = 1'b1;
         if (rsp_valid) begin
            c_rdata = rsp_rdata;
            done = 1'b1;
         end else begin
            @(negedge clk);
         end
         ph++;
      end
      nph = ph;
   endtask

   task automatic t_reset();
      chk("R1 strobes", {ext_rd_n, ext_wstb_lo_n, ext_wstb_hi_n}, 3'b111);
      chk("R1 cs", ext_cs_n, 4'hF);
      chk("R1 ale", ext_ale, 0);
      chk("R1 hlda", ext_hlda_n, 1);
      chk("R1 ready", req_ready, 1);
   endtask

   task automatic t_split16();
      cfg_bus8 = 0; cfg_split = 1; cfg_mux = 0;
      bus_op(1, 0, 20'h40010, 16'h00A5, 0);
      chk("R2 ale", c_ale[0], 1);
      chk("R2 addr", c_addr[0], 20'h40010);
      chk("R4 cs1", c_cs[0], 4'b1101);
      chk("R3 strobe len", c_slen[0], 1);
      chk("R5 even lo/hi", {c_wlo[0], c_whi[0]}, 2'b01);
      chk("R7 even lane", c_dout[0][7:0], 8'hA5);
      bus_op(1, 0, 20'hC0011, 16'h005A, 0);
      chk("R4 cs3", c_cs[0], 4'b0111);
      chk("R5 odd lo/hi", {c_wlo[0], c_whi[0]}, 2'b10);
      chk("R7 odd lane", c_dout[0][15:8], 8'h5A);
      bus_op(1, 1, 20'h00021, 16'hBEEF, 0);
      chk("R7 word addr", c_addr[0], 20'h00020);
      chk("R4 cs0", c_cs[0], 4'b1110);
      chk("R5 word both", {c_wlo[0], c_whi[0]}, 2'b00);
      chk("R7 word data", c_dout[0], 16'hBEEF);
   endtask

   task automatic t_read_wait();
      cfg_bus8 = 0; cfg_split = 1; cfg_mux = 0;
      ext_data_i = 16'h1234;
      bus_op(0, 1, 20'h80004, 16'h0, 3);
      chk("R3 stretched len", c_slen[0], 4);
      chk("R3 rd low", c_rd[0], 0);
      chk("R3 rdata word", c_rdata, 16'h1234);
      chk("R4 cs2", c_cs[0], 4'b1011);
      chk("R9 separate no drive", c_soe[0], 0);
      bus_op(0, 0, 20'h80005, 16'h0, 0);
      chk("R7 odd byte read", c_rdata, 16'h0012);
      chk("R3 nph", nph, 1);
   endtask

   task automatic t_combined16();
      cfg_bus8 = 0; cfg_split = 0; cfg_mux = 0;
      bus_op(1, 0, 20'h00013, 16'h0011, 0);
      chk("R6 wr low odd", c_wlo[0], 0);
      chk("R6 bhe low odd addr phase", c_bhe[0], 0);
      bus_op(1, 0, 20'h00012, 16'h0022, 0);
      chk("R6 wr low even", c_wlo[0], 0);
      chk("R6 bhe high even", {c_bhe[0], c_whi[0]}, 2'b11);
   endtask

   task automatic t_bus8();
      cfg_bus8 = 1; cfg_split = 1; cfg_mux = 0;
      bus_op(1, 1, 20'h40100, 16'hCAFE, 0);
      chk("R8 two phases", nph, 2);
      chk("R8 addr0", c_addr[0], 20'h40100);
      chk("R8 addr1", c_addr[1], 20'h40101);
      chk("R8 low first", c_dout[0][7:0], 8'hFE);
      chk("R8 high second", c_dout[1][7:0], 8'hCA);
      chk("R6 forced combined wr", {c_wlo[0], c_wlo[1]}, 2'b00);
      chk("R6 bhe by address", {c_bhe[0], c_bhe[1]}, 2'b10);
      ext_data_i = 16'h0077;
      bus_op(0, 1, 20'h40200, 16'h0, 1);
      chk("R8 read assembled", c_rdata, 16'h7777);
      chk("R3 len 8-bit", c_slen[1], 2);
   endtask

   task automatic t_mux();
      logic [19:0] a = 20'h2A5B6;
      cfg_mux = 1; cfg_bus8 = 0; cfg_split = 1;
      bus_op(0, 0, a, 16'h0, 0);
      chk("R9 mux drive", c_ale_doe[0], 1);
      chk("R9 mux 16 field", c_ale_data[0][7:0], a[8:1]);
      cfg_bus8 = 1;
      bus_op(0, 0, a, 16'h0, 0);
      chk("R9 mux 8 field", c_ale_data[0][7:0], a[7:0]);
      cfg_mux = 0; cfg_bus8 = 0;
      bus_op(0, 0, a, 16'h0, 0);
      chk("R9 separate no ale drive", c_ale_doe[0], 0);
   endtask

   task automatic t_hold_idle();
      logic saw_ale = 1'b0;
      @(negedge clk);
      ext_hold_n = 1'b0;
      @(negedge clk);
      chk("R10 hlda", ext_hlda_n, 0);
      chk("R10 float", {ext_ctl_oe, ext_data_oe, req_ready}, 3'b000);
      req_valid = 1'b1; req_write = 0; req_word = 0; req_addr = 20'h00100;
      repeat (3) begin
         @(negedge clk);
         if (ext_ale) saw_ale = 1'b1;
      end
      chk("R10 request waits", saw_ale, 0);
      ext_hold_n = 1'b1;
      @(negedge clk);
      chk("R10 released", ext_hlda_n, 1);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 starts after release", ext_ale, 1);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_hold_mid();
      logic bad = 1'b0;
      logic granted = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 0; req_word = 0; req_addr = 20'h00200;
      @(negedge clk);
      req_valid = 1'b0;
      ext_hold_n = 1'b0;
      ext_rdy_n = 1'b0;
      for (int k = 0; k < 10; k++) begin
         if (k == 2) ext_rdy_n = 1'b1;
         if ((ext_ale || !ext_rd_n) && !ext_hlda_n) bad = 1'b1;
         if (!ext_hlda_n) granted = 1'b1;
         @(negedge clk);
      end
      chk("R11 no grant inside cycle", bad, 0);
      chk("R11 granted after cycle", granted, 1);
      ext_hold_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_split16();
      t_read_wait();
      t_combined16();
      t_bus8();
      t_mux();
      t_hold_idle();
      t_hold_mid();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule